// File: doc/BRIEF.md
# Sleep and wake-up event controller

This block decides when a processor core goes into a low-power state and when it comes back out. The core hands it a strobe for wait-for-interrupt and one for wait-for-event. The block also receives a send-event strobe, an external event line, a debug halt request, and two levels from the interrupt controller: "something is pending" and "something pending has enough priority to run". Three configuration bits choose the sleep depth, enable automatic re-sleep on return from the last handler, and make any newly pending interrupt count as an event.

The block drives two state outputs, normal sleep and deep sleep, for the clock-gating and power logic around it. It also drives a one-cycle wake strobe and a flag that tells the core whether to enter a handler after that wake.

A one-bit event record remembers any event seen while the core is awake. A later wait-for-event uses this record to fall straight through without sleeping, and the record is cleared by that wait.

Top module: `sleep_ctl`

## Requirements
- R1: After reset the block is awake: sleep_o, deep_o, wake_o and handler_go are all 0, and the event record is clear.
- R2: A wait-for-interrupt strobe while awake always enters sleep on the next cycle. The depth is the value of cfg_deep at entry: 1 gives deep_o=1, 0 gives sleep_o=1, and the two outputs are never high together. Changing cfg_deep while asleep does not change the depth.
- R3: Sleep entered by wait-for-interrupt ends only on irq_ready=1 or dbg_req=1. ext_evt, sev_req and irq_pending alone leave the block asleep. A debug request wakes the block from either depth.
- R4: The wake strobe is high for exactly one cycle. In the cycle it is high, sleep_o and deep_o are already 0.
- R5: handler_go is 1 together with wake_o only when irq_ready=1 caused the wake and irq_mask=0. With irq_mask=1 the block still wakes, but handler_go stays 0.
- R6: A wait-for-event strobe with no recorded event enters sleep at the depth given by cfg_deep. That sleep ends on any one of irq_ready, ext_evt, sev_req or dbg_req.
- R7: When cfg_sev_on_pend=1, a 0-to-1 change of irq_pending counts as an event and wakes wait-for-event sleep. When cfg_sev_on_pend=0, the same change does not.
- R8: Any event while awake sets the event record. A wait-for-event strobe with the record set leaves the block awake and clears the record, so the next wait-for-event sleeps.
- R9: When cfg_sleep_on_exit=1, an exc_ret strobe with irq_pending=0 enters sleep on the next cycle, as wait-for-interrupt does. When irq_pending=1 or cfg_sleep_on_exit=0, the block stays awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_deep | input | 1 | Sleep depth chosen at entry (1 = deep) |
| cfg_sleep_on_exit | input | 1 | Re-enter sleep on return to thread code |
| cfg_sev_on_pend | input | 1 | Newly pending interrupt counts as an event |
| irq_mask | input | 1 | Global interrupt mask; suppresses handler entry on wake |
| wfi_req | input | 1 | Wait-for-interrupt strobe |
| wfe_req | input | 1 | Wait-for-event strobe |
| sev_req | input | 1 | Send-event strobe |
| ext_evt | input | 1 | External event input |
| dbg_req | input | 1 | Debug halt request |
| irq_pending | input | 1 | Some interrupt is pending |
| irq_ready | input | 1 | A pending interrupt has enough priority to run |
| exc_ret | input | 1 | Return from the last active handler |
| sleep_o | output | 1 | Normal sleep state |
| deep_o | output | 1 | Deep sleep state |
| wake_o | output | 1 | One-cycle wake strobe |
| handler_go | output | 1 | Enter a handler after this wake |

## Verification
The hardest state to reach from the ports is a set event record. It can only be set while the core is awake, and any later wait-for-event consumes it. The stimulus therefore pulses ext_evt on an otherwise idle awake cycle. It then issues one wait-for-event, which must fall through. A second wait-for-event follows and must sleep, which shows the record was set and then cleared. The depth latch gets similar treatment: cfg_deep is flipped while the block sleeps, and the next debug wake must come from the depth that was chosen at entry.

// File: rtl/sleep_ctl.sv
module sleep_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_deep,
  input  logic cfg_sleep_on_exit,
  input  logic cfg_sev_on_pend,
  input  logic irq_mask,
  input  logic wfi_req,
  input  logic wfe_req,
  input  logic sev_req,
  input  logic ext_evt,
  input  logic dbg_req,
  input  logic irq_pending,
  input  logic irq_ready,
  input  logic exc_ret,
  output logic sleep_o,
  output logic deep_o,
  output logic wake_o,
  output logic handler_go
);
  typedef enum logic [1:0] {ST_RUN, ST_WFI, ST_WFE} st_t;

  st_t  st;
  logic pend_q, evt_q, deep_q, wake_q, go_q;
  logic new_pend, any_evt, wake_now, soe_hit, asleep;

  assign new_pend = irq_pending & ~pend_q;
  assign any_evt  = sev_req | ext_evt | dbg_req | irq_ready | (cfg_sev_on_pend & new_pend);
  assign soe_hit  = exc_ret & cfg_sleep_on_exit & ~irq_pending;
  assign wake_now = ((st == ST_WFI) & (irq_ready | dbg_req)) | ((st == ST_WFE) & any_evt);
  assign asleep   = (st != ST_RUN);

  assign sleep_o    = asleep & ~deep_q;
  assign deep_o     = asleep & deep_q;
  assign wake_o     = wake_q;
  assign handler_go = go_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_RUN;
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
      deep_q <= 1'b0;
      wake_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      pend_q <= irq_pending;
      wake_q <= wake_now;
      go_q   <= wake_now & irq_ready & ~irq_mask;
      case (st)
        ST_RUN: begin
          if (wfi_req | soe_hit) begin
            st     <= ST_WFI;
            deep_q <= cfg_deep;
            evt_q  <= evt_q | any_evt;
          end else if (wfe_req) begin
            evt_q <= 1'b0;
            if (!(evt_q | any_evt)) begin
              st     <= ST_WFE;
              deep_q <= cfg_deep;
            end
          end else begin
            evt_q <= evt_q | any_evt;
          end
        end
        ST_WFI, ST_WFE: begin
          if (wake_now) st <= ST_RUN;
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

module sleep_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic wfi_req,
  input logic dbg_req,
  input logic irq_mask,
  input logic sleep_o,
  input logic deep_o,
  input logic wake_o,
  input logic handler_go
);
  AST_NO_DUAL_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_o && deep_o)); // R2
  AST_WFI_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_o && !deep_o && wfi_req) |=> (sleep_o || deep_o)); // R2
  AST_DBG_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((sleep_o || deep_o) && dbg_req) |=> wake_o); // R3
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o); // R4
  AST_WAKE_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!sleep_o && !deep_o && $past(sleep_o || deep_o))); // R4
  AST_GO_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    handler_go |-> wake_o); // R5
  AST_MASK_BLOCKS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    ((sleep_o || deep_o) && irq_mask) |=> !handler_go); // R5
endmodule

bind sleep_ctl sleep_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .dbg_req(dbg_req),
  .irq_mask(irq_mask), .sleep_o(sleep_o), .deep_o(deep_o),
  .wake_o(wake_o), .handler_go(handler_go)
);

// File: tb/sleep_ctl_test.sv
module sleep_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_deep = 0, cfg_sleep_on_exit = 0, cfg_sev_on_pend = 0, irq_mask = 0;
  logic wfi_req = 0, wfe_req = 0, sev_req = 0, ext_evt = 0, dbg_req = 0;
  logic irq_pending = 0, irq_ready = 0, exc_ret = 0;
  logic sleep_o, deep_o, wake_o, handler_go;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sleep_ctl uut (.*);

  // fields: deep sop mask wfe rdy ext sev dbg pnd exp_wake exp_go
  localparam int NV = 13;
  localparam logic [10:0] VEC [NV] = '{
    11'b0_0_0_0_1_0_0_0_0_1_1,
    11'b1_0_0_0_1_0_0_0_0_1_1,
    11'b0_0_1_0_1_0_0_0_0_1_0,
    11'b0_0_0_0_0_1_0_0_0_0_0,
    11'b0_0_0_0_0_0_1_0_0_0_0,
    11'b1_0_0_0_0_0_0_1_0_1_0,
    11'b0_0_0_1_0_1_0_0_0_1_0,
    11'b0_0_0_1_0_0_1_0_0_1_0,
    11'b1_0_0_1_0_0_0_1_0_1_0,
    11'b0_0_0_1_1_0_0_0_0_1_1,
    11'b0_1_0_1_0_0_0_0_1_1_0,
    11'b0_0_0_1_0_0_0_0_1_0_0,
    11'b0_0_0_0_0_0_0_0_1_0_0
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 sleep_o reset", sleep_o, 0);
    chk("R1 deep_o reset", deep_o, 0);
    chk("R1 wake_o reset", wake_o, 0);
    chk("R1 handler_go reset", handler_go, 0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      cfg_deep = v[10]; cfg_sev_on_pend = v[9]; irq_mask = v[8];
      wfe_req = v[7]; wfi_req = ~v[7];
      step();
      wfe_req = 0; wfi_req = 0;
      chk(v[7] ? "R6 wfe enters sleep depth" : "R2 wfi enters sleep depth", deep_o, v[10]);
      chk(v[7] ? "R6 wfe sleep_o" : "R2 wfi sleep_o", sleep_o, ~v[10]);
      irq_ready = v[6]; ext_evt = v[5]; sev_req = v[4]; dbg_req = v[3]; irq_pending = v[2];
      step();
      chk(v[7] ? (v[2] ? "R7 pend wake" : "R6 wfe wake") : "R3 wfi wake", wake_o, v[1]);
      chk("R5 handler_go", handler_go, v[0]);
      chk("R4 state drops with wake", sleep_o | deep_o, ~v[1]);
      irq_ready = 0; ext_evt = 0; sev_req = 0; dbg_req = 0; irq_pending = 0;
      if (!v[1]) begin
        dbg_req = 1;
        step();
        dbg_req = 0;
        chk("R3 debug wake", wake_o, 1);
      end
      step();
      chk("R4 wake one cycle", wake_o, 0);
      chk("R4 awake after wake", sleep_o | deep_o, 0);
    end

    // R8 event record: set while awake, consumed by first wfe
    cfg_deep = 0; cfg_sev_on_pend = 0; irq_mask = 0;
    ext_evt = 1; step(); ext_evt = 0; step();
    wfe_req = 1; step(); wfe_req = 0;
    chk("R8 wfe falls through", sleep_o | deep_o, 0);
    step();
    wfe_req = 1; step(); wfe_req = 0;
    chk("R8 second wfe sleeps", sleep_o, 1);
    dbg_req = 1; step(); dbg_req = 0; step();

    // R2 depth fixed at entry
    cfg_deep = 1; wfi_req = 1; step(); wfi_req = 0;
    cfg_deep = 0; step(); step();
    chk("R2 depth held after cfg change", deep_o, 1);
    chk("R2 no normal sleep", sleep_o, 0);
    dbg_req = 1; step(); dbg_req = 0;
    chk("R3 debug wakes deep", wake_o, 1);
    step();

    // R9 sleep on exit
    cfg_sleep_on_exit = 1; exc_ret = 1; step(); exc_ret = 0;
    chk("R9 exit re-sleeps", sleep_o, 1);
    dbg_req = 1; step(); dbg_req = 0; step();
    irq_pending = 1; step();
    exc_ret = 1; step(); exc_ret = 0;
    chk("R9 pending blocks re-sleep", sleep_o | deep_o, 0);
    irq_pending = 0; step();
    cfg_sleep_on_exit = 0; exc_ret = 1; step(); exc_ret = 0;
    chk("R9 bit clear stays awake", sleep_o | deep_o, 0);
    step();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule